// File: doc/BRIEF.md
# PLL Output Divider Retune Sequencer

This block retunes the first output clock of a PLL through its dynamic reconfiguration port. A host supplies an integer divide value and pulses `start`. The sequencer holds the PLL in reset and reads the output-0 divider word at port address 0x08. It replaces only the two count fields and writes the word back. It then releases reset and waits for the PLL to lose and regain lock before pulsing `done`.

A sweep mode steps the divider through the even values 12, 14, ... 42. This gives roughly 133 MHz down to 38 MHz from a 1.6 GHz VCO. Every value gets its own read-modify-write and lock wait. The sequencer moves to the next value only after the host acknowledges the previous `done`.

Every port access is guarded by a timeout that the host sets. Divide values outside the range the count fields can hold are refused. So is a start that arrives while the sequencer is active.

The FSM has ten states:

| State | Role | Leaves when |
|---|---|---|
| IDLE | Waits for work | an accepted start moves it to HOLD |
| HOLD | Asserts PLL reset and arms the lock watch | next cycle, to RD_REQ |
| RD_REQ | Issues the read | next cycle, to RD_WAIT |
| RD_WAIT | Waits for the read | ready moves it to WR_REQ; timeout moves it to IDLE |
| WR_REQ | Issues the write | next cycle, to WR_WAIT |
| WR_WAIT | Waits for the write | ready moves it to RELEASE; timeout moves it to IDLE |
| RELEASE | Drops reset | next cycle, to WAIT_LOCK |
| WAIT_LOCK | Waits for lock | lock seen low, then high, moves it to DONE |
| DONE | Pulses `done` | next cycle, to WAIT_ACK in sweep mode, otherwise to IDLE |
| WAIT_ACK | Holds in sweep mode | `sweep_ack` moves it to HOLD, or to IDLE after the value 42 |

Top module: `pll_div_retune`

## Requirements
- R1: An accepted single start makes exactly two port accesses, both at address 0x08: first a read (`drp_we`=0), then a write (`drp_we`=1).
- R2: For divide value D, the written word keeps bits 15:12 of the read word unchanged. Bits 11:6 become ceil(D/2) and bits 5:0 become floor(D/2).
- R3: A single-mode start with D<2 or D>126 sets `err_range`. It makes no port access and the block stays idle (`busy`=0).
- R4: A start while `busy`=1 sets `err_busy` and is otherwise ignored. The running operation finishes with its own divide value.
- R5: `drp_en` is high for one cycle per access. `drp_we` is high only together with `drp_en`. No new access starts before the previous one receives `drp_rdy`.
- R6: If `drp_rdy` does not arrive within `timeout_limit` cycles, `err_timeout` is set and the sequence aborts to idle with `pll_rst` released. No `done` follows.
- R7: `pll_rst` is high from the cycle after an accepted start until the write is acknowledged. It is also high whenever `ref_locked`=0.
- R8: `done` is a one-cycle pulse. It comes only after `pll_locked` has been seen low after the reset began and has then returned high.
- R9: A start with `sweep_mode`=1 performs one read-modify-write per even value from 12 to 42, in rising order. `cur_div` shows the value in use.
- R10: In sweep mode the block advances only on a `sweep_ack` pulse after each `done`. An acknowledge after value 42 returns the block to idle.
- R11: After reset the block is idle: `busy`, `done`, `drp_en` and all error flags are 0, and `pll_rst` follows only `ref_locked`.
- R12: Error flags stay set until the next accepted start, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin |
| sweep_mode | input | 1 | Sampled with start: 1 selects the sweep |
| div_value | input | 8 | Divide value for a single retune |
| sweep_ack | input | 1 | Host acknowledge that lets the sweep advance |
| timeout_limit | input | 16 | Cycles allowed per port access |
| ref_locked | input | 1 | Lock of the upstream reference PLL |
| pll_locked | input | 1 | Lock of the PLL being retuned |
| pll_rst | output | 1 | Reset to the PLL being retuned |
| drp_en | output | 1 | Port access strobe |
| drp_we | output | 1 | Port write qualifier |
| drp_addr | output | 7 | Port address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port access complete |
| busy | output | 1 | Sequence active |
| done | output | 1 | Retune complete and relocked (pulse) |
| cur_div | output | 8 | Divide value currently applied |
| err_range | output | 1 | Divide value refused |
| err_busy | output | 1 | Start arrived while active |
| err_timeout | output | 1 | Port access timed out |

## Verification
Single retunes are run with an even value, an odd value and the two range limits 2 and 126. Upper register bits are preloaded with different patterns. The odd value shows whether high and low counts are split in the right direction, and the preloads show whether the kept fields survive. A sweep run checks value order, the hold without acknowledge, and the exit after 42. Separate runs with a silent port, a late second start and a dropped reference lock each isolate one abort or guard path.

// File: rtl/pll_retune_pkg.sv
`timescale 1ns/1ps
package pll_retune_pkg;

    // Sequencer states, in order of a normal pass
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RELEASE,
        ST_WAIT_LOCK,
        ST_DONE,
        ST_WAIT_ACK
    } seq_state_t;

    // Width of one count field in the divider word
    localparam int CNT_FIELD_W = 6;

endpackage

// File: rtl/pll_drp_port.sv
`timescale 1ns/1ps
// Single-access engine: one-cycle strobe, wait for ready, bounded by a timeout.
module pll_drp_port #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              ack,
    output logic              tmo,
    output logic [DATA_W-1:0] rdata,
    output logic              drp_en,
    output logic              drp_we,
    output logic [ADDR_W-1:0] drp_addr,
    output logic [DATA_W-1:0] drp_di,
    input  logic [DATA_W-1:0] drp_do,
    input  logic              drp_rdy
);

    logic             pend;
    logic [TMO_W-1:0] wait_cnt;
    logic             limit_hit;

    assign limit_hit = (wait_cnt == tmo_limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            wait_cnt <= '0;
            drp_en   <= 1'b0;
            drp_we   <= 1'b0;
            drp_addr <= '0;
            drp_di   <= '0;
        end else begin
            drp_en <= 1'b0;
            drp_we <= 1'b0;
            if (!pend) begin
                if (req) begin
                    drp_en   <= 1'b1;
                    drp_we   <= req_we;
                    drp_addr <= req_addr;
                    drp_di   <= req_wdata;
                    pend     <= 1'b1;
                    wait_cnt <= '0;
                end
            end else if (drp_rdy || limit_hit) begin
                pend <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    assign ack   = pend & drp_rdy;
    assign tmo   = pend & ~drp_rdy & limit_hit;
    assign rdata = drp_do;

endmodule

// File: rtl/pll_div_word.sv
`timescale 1ns/1ps
// Replaces the high and low count fields of a divider word.
module pll_div_word #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [CNT_W:0]    div,
    output logic [DATA_W-1:0] new_word
);

    localparam int KEEP_LSB = 2 * CNT_W;
    localparam logic [DATA_W-1:0] CNT_MASK = DATA_W'((1 << KEEP_LSB) - 1);

    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;

    // low = floor(D/2), high = floor(D/2) + (D mod 2)
    assign lo_cnt   = div[CNT_W:1];
    assign hi_cnt   = div[CNT_W:1] + {{(CNT_W-1){1'b0}}, div[0]};
    assign new_word = (old_word & ~CNT_MASK)
                    | {{(DATA_W-KEEP_LSB){1'b0}}, hi_cnt, lo_cnt};

endmodule

// File: rtl/pll_lock_watch.sv
`timescale 1ns/1ps
// Reports relock only after lock has been seen low since arming.
module pll_lock_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pll_locked,
    output logic relocked
);

    logic dropped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropped <= 1'b0;
        end else if (arm) begin
            dropped <= 1'b0;
        end else if (!pll_locked) begin
            dropped <= 1'b1;
        end
    end

    assign relocked = dropped & pll_locked;

endmodule

// File: rtl/pll_div_retune.sv
`timescale 1ns/1ps
module pll_div_retune
    import pll_retune_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 8,
    parameter int TMO_W       = 16,
    parameter int DIV_ADDR    = 8,
    parameter int MIN_DIV     = 2,
    parameter int SWEEP_FIRST = 12,
    parameter int SWEEP_LAST  = 42,
    parameter int SWEEP_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sweep_mode,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              sweep_ack,
    input  logic [TMO_W-1:0]  timeout_limit,
    input  logic              ref_locked,
    input  logic              pll_locked,
    output logic              pll_rst,
    output logic              drp_en,
    output logic              drp_we,
    output logic [ADDR_W-1:0] drp_addr,
    output logic [DATA_W-1:0] drp_di,
    input  logic [DATA_W-1:0] drp_do,
    input  logic              drp_rdy,
    output logic              busy,
    output logic              done,
    output logic [DIV_W-1:0]  cur_div,
    output logic              err_range,
    output logic              err_busy,
    output logic              err_timeout
);

    localparam int CNT_W   = CNT_FIELD_W;
    localparam int MAX_DIV = 2 * ((1 << CNT_W) - 1);
    localparam logic [DIV_W-1:0]  MIN_D   = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0]  MAX_D   = DIV_W'(MAX_DIV);
    localparam logic [DIV_W-1:0]  FIRST_D = DIV_W'(SWEEP_FIRST);
    localparam logic [DIV_W-1:0]  LAST_D  = DIV_W'(SWEEP_LAST);
    localparam logic [DIV_W-1:0]  STEP_D  = DIV_W'(SWEEP_STEP);
    localparam logic [ADDR_W-1:0] REG_A   = ADDR_W'(DIV_ADDR);

    seq_state_t        state, state_nx;
    logic [DIV_W-1:0]  div_r;
    logic [DATA_W-1:0] word_r;
    logic [DATA_W-1:0] word_new;
    logic              sweep_r;
    logic              in_range;
    logic              at_last;
    logic              port_req, port_req_we, port_ack, port_tmo;
    logic [DATA_W-1:0] port_rdata;
    logic              hold_rst, arm_watch, relocked;

    assign in_range = (div_value >= MIN_D) && (div_value <= MAX_D);
    assign at_last  = (div_r >= LAST_D);

    // Sub-blocks
    pll_drp_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TMO_W  (TMO_W)
    ) i_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (port_req),
        .req_we    (port_req_we),
        .req_addr  (REG_A),
        .req_wdata (word_new),
        .tmo_limit (timeout_limit),
        .ack       (port_ack),
        .tmo       (port_tmo),
        .rdata     (port_rdata),
        .drp_en    (drp_en),
        .drp_we    (drp_we),
        .drp_addr  (drp_addr),
        .drp_di    (drp_di),
        .drp_do    (drp_do),
        .drp_rdy   (drp_rdy)
    );

    pll_div_word #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_word (
        .old_word (word_r),
        .div      (div_r[CNT_W:0]),
        .new_word (word_new)
    );

    pll_lock_watch i_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm_watch),
        .pll_locked (pll_locked),
        .relocked   (relocked)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start && (sweep_mode || in_range)) state_nx = ST_HOLD;
            ST_HOLD:      state_nx = ST_RD_REQ;
            ST_RD_REQ:    state_nx = ST_RD_WAIT;
            ST_RD_WAIT:   if (port_ack) state_nx = ST_WR_REQ;
                          else if (port_tmo) state_nx = ST_IDLE;
            ST_WR_REQ:    state_nx = ST_WR_WAIT;
            ST_WR_WAIT:   if (port_ack) state_nx = ST_RELEASE;
                          else if (port_tmo) state_nx = ST_IDLE;
            ST_RELEASE:   state_nx = ST_WAIT_LOCK;
            ST_WAIT_LOCK: if (relocked) state_nx = ST_DONE;
            ST_DONE:      state_nx = sweep_r ? ST_WAIT_ACK : ST_IDLE;
            ST_WAIT_ACK:  if (sweep_ack) state_nx = at_last ? ST_IDLE : ST_HOLD;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        hold_rst    = (state inside {ST_HOLD, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT});
        port_req    = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        port_req_we = (state == ST_WR_REQ);
        arm_watch   = (state == ST_HOLD);
    end

    assign pll_rst = hold_rst | ~ref_locked;
    assign cur_div = div_r;

    // Working registers and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_r       <= '0;
            word_r      <= '0;
            sweep_r     <= 1'b0;
            err_range   <= 1'b0;
            err_busy    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                if (sweep_mode || in_range) begin
                    sweep_r     <= sweep_mode;
                    div_r       <= sweep_mode ? FIRST_D : div_value;
                    err_range   <= 1'b0;
                    err_busy    <= 1'b0;
                    err_timeout <= 1'b0;
                end else begin
                    err_range <= 1'b1;
                end
            end
            if (state != ST_IDLE && start) begin
                err_busy <= 1'b1;
            end
            if (state == ST_RD_WAIT && port_ack) begin
                word_r <= port_rdata;
            end
            if (port_tmo) begin
                err_timeout <= 1'b1;
            end
            if (state == ST_WAIT_ACK && sweep_ack && !at_last) begin
                div_r <= div_r + STEP_D;
            end
        end
    end

endmodule

// File: rtl/pll_retune_checker.sv
`timescale 1ns/1ps
module pll_retune_checker #(
    parameter int ADDR_W   = 7,
    parameter int DIV_ADDR = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drp_en,
    input logic              drp_we,
    input logic [ADDR_W-1:0] drp_addr,
    input logic              pll_rst,
    input logic              pll_locked,
    input logic              done,
    input logic              busy
);

    assert_addr_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> (drp_addr == ADDR_W'(DIV_ADDR)));

    assert_idle_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drp_en);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);

    assert_we_with_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en);

    assert_rst_during_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> pll_rst);

    assert_done_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pll_locked));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind pll_div_retune pll_retune_checker #(
    .ADDR_W   (ADDR_W),
    .DIV_ADDR (DIV_ADDR)
) i_pll_retune_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .drp_en     (drp_en),
    .drp_we     (drp_we),
    .drp_addr   (drp_addr),
    .pll_rst    (pll_rst),
    .pll_locked (pll_locked),
    .done       (done),
    .busy       (busy)
);

// File: tb/test_pll_div_retune.sv
`timescale 1ns/1ps
module test_pll_div_retune;

    localparam int CLK_PERIOD = 10;
    localparam int RDY_LAT    = 2;
    localparam int LOCK_LAT   = 6;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sweep_mode = 1'b0;
    logic [7:0]  div_value = '0;
    logic        sweep_ack = 1'b0;
    logic [15:0] timeout_limit = 16'd40;
    logic        ref_locked = 1'b1;
    logic        pll_locked;
    logic        pll_rst;
    logic        drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do;
    logic        drp_rdy;
    logic        busy, done;
    logic [7:0]  cur_div;
    logic        err_range, err_busy, err_timeout;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_div_retune i_pll_div_retune (
        .clk(clk), .rst_n(rst_n), .start(start), .sweep_mode(sweep_mode),
        .div_value(div_value), .sweep_ack(sweep_ack), .timeout_limit(timeout_limit),
        .ref_locked(ref_locked), .pll_locked(pll_locked), .pll_rst(pll_rst),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_do(drp_do), .drp_rdy(drp_rdy), .busy(busy), .done(done),
        .cur_div(cur_div), .err_range(err_range), .err_busy(err_busy),
        .err_timeout(err_timeout)
    );

    // Port model: one divider register, ready RDY_LAT cycles after the strobe
    logic        mute = 1'b0;
    logic        pre_go = 1'b0;
    logic [15:0] pre_val = '0;
    logic [15:0] m_reg = '0;
    logic        m_pend = 1'b0, m_we = 1'b0;
    logic [6:0]  m_addr = '0;
    logic [15:0] m_di = '0;
    int          m_cnt = 0;
    logic        m_rdy = 1'b0;
    logic [15:0] m_do = '0;
    logic [7:0]  we_log = '0;
    int acc_count = 0, addr_bad = 0, rst_viol = 0, ovl_viol = 0, en_viol = 0;
    logic        prev_en = 1'b0;

    assign drp_rdy = m_rdy;
    assign drp_do  = m_do;

    always @(posedge clk) begin
        m_rdy   <= 1'b0;
        prev_en <= drp_en;
        if (prev_en && drp_en) en_viol <= en_viol + 1;
        if (pre_go) m_reg <= pre_val;
        if (drp_en) begin
            if (m_pend && !mute) ovl_viol <= ovl_viol + 1;
            m_pend    <= 1'b1;
            m_cnt     <= RDY_LAT;
            m_we      <= drp_we;
            m_addr    <= drp_addr;
            m_di      <= drp_di;
            acc_count <= acc_count + 1;
            we_log    <= {we_log[6:0], drp_we};
            if (drp_addr != 7'h08) addr_bad <= addr_bad + 1;
            if (!pll_rst) rst_viol <= rst_viol + 1;
        end else if (drp_we) begin
            en_viol <= en_viol + 1;
        end else if (m_pend && !mute) begin
            if (m_cnt == 0) begin
                m_pend <= 1'b0;
                m_rdy  <= 1'b1;
                m_do   <= m_reg;
                if (m_we && m_addr == 7'h08) m_reg <= m_di;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    // PLL model: loses lock in reset, relocks LOCK_LAT cycles after release
    logic lk = 1'b1;
    int   lcnt = 0;
    int   done_cnt = 0, done_viol = 0;
    assign pll_locked = lk;

    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (done && !pll_locked) done_viol <= done_viol + 1;
        if (pll_rst) begin
            lk   <= 1'b0;
            lcnt <= 0;
        end else if (!lk) begin
            if (lcnt == LOCK_LAT) lk <= 1'b1;
            else lcnt <= lcnt + 1;
        end
    end

    // Helpers
    function automatic logic [15:0] exp_word(input logic [15:0] old, input int d);
        return (old & 16'hF000) | 16'(((d + 1) / 2) << 6) | 16'(d / 2);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [15:0] v);
        @(negedge clk);
        pre_val = v;
        pre_go  = 1'b1;
        @(negedge clk);
        pre_go  = 1'b0;
    endtask

    task automatic pulse_start(input int d, input bit sw);
        @(negedge clk);
        start      = 1'b1;
        div_value  = 8'(d);
        sweep_mode = sw;
        @(negedge clk);
        start      = 1'b0;
        sweep_mode = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Scenarios
    task automatic t_reset();
        check(busy == 0, "R11", "busy after reset", busy, 0);
        check(done == 0, "R11", "done after reset", done, 0);
        check(drp_en == 0, "R11", "drp_en after reset", drp_en, 0);
        check({err_range, err_busy, err_timeout} == 0, "R11", "errors after reset",
              {err_range, err_busy, err_timeout}, 0);
        check(pll_rst == 0, "R11", "pll_rst with ref locked", pll_rst, 0);
    endtask

    task automatic t_single(input string req, input logic [15:0] old, input int d);
        int a0;
        bit seen;
        preload(old);
        a0 = acc_count;
        pulse_start(d, 1'b0);
        check(err_range == 0, "R12", "err_range cleared by accepted start", err_range, 0);
        wait_done(seen);
        check(seen, "R8", "done pulse seen", seen, 1);
        check(m_reg == exp_word(old, d), req, "written word", m_reg, exp_word(old, d));
        check(acc_count - a0 == 2, "R1", "access count", acc_count - a0, 2);
        check(we_log[1:0] == 2'b01, "R1", "read then write order", we_log[1:0], 2'b01);
        @(negedge clk);
        check(done == 0, "R8", "done lasts one cycle", done, 0);
        check(busy == 0, "R1", "idle after single retune", busy, 0);
    endtask

    task automatic t_range(input int d);
        int a0;
        a0 = acc_count;
        pulse_start(d, 1'b0);
        check(err_range == 1, "R3", "err_range on bad value", err_range, 1);
        check(busy == 0, "R3", "stays idle on bad value", busy, 0);
        repeat (10) @(negedge clk);
        check(acc_count == a0, "R3", "no access on bad value", acc_count - a0, 0);
        check(err_range == 1, "R12", "err_range sticky", err_range, 1);
    endtask

    task automatic t_busy_start();
        bit seen;
        preload(16'h2000);
        pulse_start(20, 1'b0);
        repeat (2) @(negedge clk);
        pulse_start(30, 1'b0);
        check(err_busy == 1, "R4", "err_busy on start while active", err_busy, 1);
        wait_done(seen);
        check(seen, "R4", "running retune completes", seen, 1);
        check(m_reg == exp_word(16'h2000, 20), "R4", "first value kept",
              m_reg, exp_word(16'h2000, 20));
        check(cur_div == 8'd20, "R4", "cur_div unchanged", cur_div, 20);
        repeat (2) @(negedge clk);
        check(busy == 0, "R4", "no second retune", busy, 0);
    endtask

    task automatic t_timeout();
        int a0, d0;
        preload(16'h1234);
        a0 = acc_count;
        d0 = done_cnt;
        mute = 1'b1;
        pulse_start(20, 1'b0);
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check(err_timeout == 1, "R6", "err_timeout set", err_timeout, 1);
        check(busy == 0, "R6", "aborted to idle", busy, 0);
        check(pll_rst == 0, "R6", "reset released after abort", pll_rst, 0);
        check(acc_count - a0 == 1, "R6", "only the read issued", acc_count - a0, 1);
        check(m_reg == 16'h1234, "R6", "register untouched", m_reg, 16'h1234);
        repeat (20) @(negedge clk);
        check(done_cnt == d0, "R6", "no done after abort", done_cnt - d0, 0);
        mute = 1'b0;
        preload(16'h1234);
        pulse_start(10, 1'b0);
        check(err_timeout == 0, "R12", "err_timeout cleared by start", err_timeout, 0);
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic t_ref_lock();
        @(negedge clk);
        ref_locked = 1'b0;
        @(negedge clk);
        check(pll_rst == 1, "R7", "pll_rst while reference unlocked", pll_rst, 1);
        ref_locked = 1'b1;
        @(negedge clk);
        check(pll_rst == 0, "R7", "pll_rst follows reference lock", pll_rst, 0);
        repeat (LOCK_LAT + 4) @(negedge clk);
    endtask

    task automatic t_sweep();
        int a0;
        bit seen;
        preload(16'h5000);
        a0 = acc_count;
        pulse_start(0, 1'b1);
        for (int d = 12; d <= 42; d += 2) begin
            wait_done(seen);
            if (!seen || cur_div != 8'(d) || m_reg != exp_word(16'h5000, d)) begin
                check(seen, "R9", "sweep done", seen, 1);
                check(cur_div == 8'(d), "R9", "sweep value", cur_div, d);
                check(m_reg == exp_word(16'h5000, d), "R9", "sweep word",
                      m_reg, exp_word(16'h5000, d));
            end
            if (d == 12) begin
                check(m_reg == exp_word(16'h5000, 12), "R9", "first sweep word",
                      m_reg, exp_word(16'h5000, 12));
                repeat (15) @(negedge clk);
                check(acc_count - a0 == 2, "R10", "hold without ack", acc_count - a0, 2);
                check(busy == 1, "R10", "busy while waiting ack", busy, 1);
            end
            @(negedge clk);
            sweep_ack = 1'b1;
            @(negedge clk);
            sweep_ack = 1'b0;
        end
        check(busy == 0, "R10", "idle after last ack", busy, 0);
        check(cur_div == 8'd42, "R9", "last sweep value", cur_div, 42);
        check(acc_count - a0 == 32, "R9", "sweep access count", acc_count - a0, 32);
    endtask

    // Watchdog
    bit finished = 1'b0;
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single("R2", 16'h3208, 20);
        t_single("R2", 16'hFFFF, 7);
        t_range(1);
        t_range(127);
        t_single("R2", 16'hA000, 2);
        t_single("R2", 16'h0FC0, 126);
        t_busy_start();
        t_timeout();
        t_ref_lock();
        t_sweep();
        check(rst_viol == 0, "R7", "access without pll_rst", rst_viol, 0);
        check(en_viol == 0, "R5", "strobe longer than one cycle", en_viol, 0);
        check(ovl_viol == 0, "R5", "access before ready", ovl_viol, 0);
        check(addr_bad == 0, "R1", "access to other address", addr_bad, 0);
        check(done_viol == 0, "R8", "done without lock", done_viol, 0);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule